// File: doc/BRIEF.md
# Frame Memory Serial Dump Sequencer

Once a frame has been captured, this block streams the entire frame memory out of a single asynchronous serial line. It walks the memory from address zero up to the last location. It sends every stored word as one serial character, and it treats the line-marker words written during retrace exactly like pixel samples. The read address is paced by a bit-rate divider running from the system clock, not by the camera's pixel clock. Each character carries 8 data bits, an odd parity bit and one stop bit at 9600 baud by default.

The memory is external and synchronous: its data appears one clock after the address is presented. A single-cycle start request launches a dump. A busy level covers the whole transfer, and a one-cycle done pulse marks its end. Between dumps the line rests high.

Top module: `fdump_serial_seq`

## Requirements
- R1: After synchronous reset, `tx_o` is 1, `busy_o` is 0, `done_o` is 0 and `rd_addr_o` is 0.
- R2: A start request sampled while idle begins a dump at address 0, and `busy_o` is 1 from the next cycle until the dump ends.
- R3: Each character is a 0 start bit, then the stored word zero-extended to 8 bits and sent least significant bit first, then a parity bit making the count of ones in the 8 data bits plus parity odd, then a 1 stop bit.
- R4: Every bit lasts DIV clocks, where DIV is CLK_HZ/BAUD rounded to the nearest integer. BAUD defaults to 9600, and at the default clock the bit period lies within 2% of nominal.
- R5: Words go out in ascending address order, 0 through DEPTH-1, one character per location, and a marker word such as 6'b101010 is sent like any other value.
- R6: The read address holds for the whole of a character and steps by one only after that character's stop bit has completed. The next start bit begins only after the new word has been read.
- R7: After the stop bit of location DEPTH-1, `done_o` is 1 for exactly one cycle, `busy_o` falls in that same cycle, and `tx_o` stays 1 until another dump begins.
- R8: A start request while `busy_o` is 1 is ignored: the address sequence and the characters continue unchanged.
- R9: A start request sampled in the cycle where `done_o` is 1 is accepted, and a new dump restarts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Dump request, sampled on the rising edge |
| rd_data_i | input | WORD_W | Memory read data, valid one cycle after the address |
| rd_addr_o | output | ADDR_W | Memory read address |
| tx_o | output | 1 | Serial transmit line, idles high |
| busy_o | output | 1 | High while a dump is in progress |
| done_o | output | 1 | One-cycle pulse when the last character has finished |

## Verification
Two functions can coincide: the end-of-dump pulse and a new start request. Sampling the request in the done cycle must restart at address 0. A request one cycle earlier, during the final stop bit, must be lost.

The bench waits at the falling clock edge until it sees `done_o` high, raises the request in that very cycle, and then checks that `busy_o` is back up with the address at zero. It also checks that the following dump reproduces every word.

A request injected in the middle of a dump, while a stop bit is on the line, is judged by the address staying put and the remaining characters arriving unchanged.

// File: rtl/fdump_pkg.sv
package fdump_pkg;

    // Sequencer phases: idle, address presented, data captured, shifting.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ADDR  = 2'd1,
        ST_LOAD  = 2'd2,
        ST_SHIFT = 2'd3
    } seq_state_e;

    localparam int CHAR_DATA_W = 8;
    localparam int FRAME_BITS  = CHAR_DATA_W + 3;   // start + data + parity + stop

    // One serial character, bit 0 leaves the line first.
    typedef struct packed {
        logic                   stop;
        logic                   parity;
        logic [CHAR_DATA_W-1:0] data;
        logic                   start;
    } char_frame_t;

    // Clocks per bit, rounded to nearest.
    function automatic int baud_divisor(input int clk_hz, input int baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

    // Bit that makes the total number of ones odd.
    function automatic logic odd_parity(input logic [CHAR_DATA_W-1:0] d);
        return ~(^d);
    endfunction

    function automatic char_frame_t build_frame(input logic [CHAR_DATA_W-1:0] d);
        char_frame_t f;
        f.start  = 1'b0;
        f.data   = d;
        f.parity = odd_parity(d);
        f.stop   = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/fdump_baud_gen.sv
module fdump_baud_gen #(
    parameter int DIV = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counter restarts whenever the shifter is not running, so each
    // character begins on a fresh full bit period.
    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == CNT_LAST);

    assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= CNT_LAST);

    assert_tick_restart_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o);

endmodule

// File: rtl/fdump_char_tx.sv
module fdump_char_tx
    import fdump_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              tick_i,
    output logic              tx_o,
    output logic              char_end_o
);
    localparam int BCNT_W = $clog2(FRAME_BITS);
    localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(FRAME_BITS - 1);

    logic [CHAR_DATA_W-1:0] data_ext;
    char_frame_t            frame_d;
    logic [FRAME_BITS-1:0]  shreg_q;
    logic [BCNT_W-1:0]      bcnt_q;

    // Stored word to 8-bit character payload.
    generate
        if (WORD_W < CHAR_DATA_W) begin : g_zext
            assign data_ext = {{(CHAR_DATA_W - WORD_W){1'b0}}, word_i};
        end else begin : g_trunc
            assign data_ext = word_i[CHAR_DATA_W-1:0];
        end
    endgenerate

    assign frame_d = build_frame(data_ext);

    // Shift register idles all ones; ones are shifted in behind the frame.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shreg_q <= '1;
            bcnt_q  <= '0;
        end else if (load_i) begin
            shreg_q <= frame_d;
            bcnt_q  <= '0;
        end else if (tick_i) begin
            shreg_q <= {1'b1, shreg_q[FRAME_BITS-1:1]};
            bcnt_q  <= (bcnt_q == BCNT_LAST) ? '0 : bcnt_q + 1'b1;
        end
    end

    assign tx_o       = shreg_q[0];
    assign char_end_o = tick_i && (bcnt_q == BCNT_LAST);

    assert_bitcnt_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        bcnt_q <= BCNT_LAST);

    assert_start_bit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> !tx_o);

    assert_stop_bit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        char_end_o |-> tx_o);

endmodule

// File: rtl/fdump_seq_ctrl.sv
module fdump_seq_ctrl
    import fdump_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic              char_end_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              load_o,
    output logic              shift_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    logic              last_loc;

    assign last_loc = (addr_q == ADDR_LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        addr_q  <= '0;
                        state_q <= ST_ADDR;
                    end
                end
                // Address is on the bus; memory registers it this edge.
                ST_ADDR:  state_q <= ST_LOAD;
                // Read data valid; character frame is loaded this edge.
                ST_LOAD:  state_q <= ST_SHIFT;
                ST_SHIFT: begin
                    if (char_end_i) begin
                        if (last_loc) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            addr_q  <= addr_q + 1'b1;
                            state_q <= ST_ADDR;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_addr_o = addr_q;
    assign load_o    = (state_q == ST_LOAD);
    assign shift_o   = (state_q == ST_SHIFT);
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;

    assert_start_idle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && start_i) |=> (busy_o && rd_addr_o == '0));

    assert_addr_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (busy_o && !(shift_o && char_end_i)) |=> $stable(rd_addr_o));

    assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (shift_o && char_end_i && !last_loc) |=> (rd_addr_o == $past(rd_addr_o) + 1'b1));

    assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !busy_o);

endmodule

// File: rtl/fdump_serial_seq.sv
module fdump_serial_seq
    import fdump_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 9600,
    parameter int WORD_W = 6,
    parameter int DEPTH  = 208 * 288,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int DIV = baud_divisor(CLK_HZ, BAUD);

    logic load;
    logic shift_run;
    logic tick;
    logic char_end;

    fdump_seq_ctrl #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .char_end_i (char_end),
        .rd_addr_o  (rd_addr_o),
        .load_o     (load),
        .shift_o    (shift_run),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    fdump_baud_gen #(
        .DIV (DIV)
    ) u_baud (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .run_i  (shift_run),
        .tick_o (tick)
    );

    fdump_char_tx #(
        .WORD_W (WORD_W)
    ) u_tx (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .load_i     (load),
        .word_i     (rd_data_i),
        .tick_i     (tick),
        .tx_o       (tx_o),
        .char_end_o (char_end)
    );

    // Line rests high whenever no dump is running.
    assert_idle_line_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> tx_o);

    assert_done_after_busy_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(done_o) |-> $past(busy_o));

endmodule

// File: tb/fdump_serial_seq_tb_top.sv
module fdump_serial_seq_tb_top;

    localparam int CLK_HZ = 96_000;
    localparam int BAUD   = 9600;
    localparam int WORD_W = 6;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 3;
    localparam int DIV    = 10;   // 96000 / 9600

    // {word, expected odd-parity bit}
    localparam logic [6:0] VEC [DEPTH] = '{
        {6'h00, 1'b1}, {6'h2A, 1'b0}, {6'h3F, 1'b1}, {6'h01, 1'b0},
        {6'h15, 1'b0}, {6'h20, 1'b0}, {6'h0C, 1'b1}, {6'h2A, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              start;
    logic [WORD_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              tx, busy, done;
    logic [WORD_W-1:0] mem [DEPTH];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;
    always_ff @(posedge clk) cycles <= cycles + 1;

    always_ff @(posedge clk) rd_data <= mem[rd_addr];

    fdump_serial_seq #(
        .CLK_HZ (CLK_HZ), .BAUD (BAUD), .WORD_W (WORD_W),
        .DEPTH (DEPTH), .ADDR_W (ADDR_W)
    ) dut_i (
        .clk_i (clk), .rst_i (rst), .start_i (start),
        .rd_data_i (rd_data), .rd_addr_o (rd_addr),
        .tx_o (tx), .busy_o (busy), .done_o (done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Independent line receiver; sampling on falling clock edges.
    task automatic rx_char(output logic seen, output logic [7:0] d, output logic p,
                           output logic s, output logic st_ok, output logic b0,
                           output logic [ADDR_W-1:0] a_mid, output logic [ADDR_W-1:0] a_stop);
        seen = 1'b0; d = '0; p = 1'b0; s = 1'b0; st_ok = 1'b1; b0 = 1'b0;
        a_mid = '0; a_stop = '0;
        for (int w = 0; w < 40 * DIV && !seen; w++) begin
            @(negedge clk);
            if (tx === 1'b0) seen = 1'b1;
        end
        if (seen) begin
            for (int c = 1; c <= 10 * DIV + DIV / 2; c++) begin
                @(negedge clk);
                if (c < DIV && tx !== 1'b0) st_ok = 1'b0;
                if (c == DIV) b0 = tx;
                if (c == DIV / 2) a_mid = rd_addr;
                for (int j = 1; j <= 8; j++)
                    if (c == j * DIV + DIV / 2) d[j-1] = tx;
                if (c == 9 * DIV + DIV / 2) p = tx;
                if (c == 10 * DIV + DIV / 2) begin
                    s = tx;
                    a_stop = rd_addr;
                end
            end
        end
    endtask

    task automatic run_dump(input bit poke_busy, input bit restart);
        logic seen, p, s, st_ok, b0;
        logic [7:0] d;
        logic [ADDR_W-1:0] a_mid, a_stop;
        bit got_done;
        for (int i = 0; i < DEPTH; i++) begin
            rx_char(seen, d, p, s, st_ok, b0, a_mid, a_stop);
            check("R5 character present", 32'(seen), 32'd1);
            check("R3 data byte", 32'(d), 32'({2'b00, VEC[i][6:1]}));
            check("R3 odd parity", 32'(p), 32'(VEC[i][0]));
            check("R3 stop bit", 32'(s), 32'd1);
            check("R4 start bit low for DIV clocks", 32'(st_ok), 32'd1);
            check("R4 first data bit after DIV clocks", 32'(b0), 32'(VEC[i][1]));
            check("R5 address during character", 32'(a_mid), 32'(i));
            check("R6 address held through stop bit", 32'(a_stop), 32'(i));
            if (poke_busy && i == 3) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R8 busy kept", 32'(busy), 32'd1);
                check("R8 address unchanged", 32'(rd_addr), 32'd3);
            end
        end
        got_done = 1'b0;
        for (int w = 0; w < 3 * DIV && !got_done; w++) begin
            @(negedge clk);
            if (done === 1'b1) got_done = 1'b1;
        end
        check("R7 done pulse seen", 32'(got_done), 32'd1);
        check("R7 busy low with done", 32'(busy), 32'd0);
        check("R7 line high at done", 32'(tx), 32'd1);
        if (restart) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R9 restart busy", 32'(busy), 32'd1);
            check("R9 restart address zero", 32'(rd_addr), 32'd0);
            check("R7 done one cycle", 32'(done), 32'd0);
        end else begin
            @(negedge clk);
            check("R7 done one cycle", 32'(done), 32'd0);
            for (int w = 0; w < 3 * DIV; w++) begin
                @(negedge clk);
                if (tx !== 1'b1 || busy !== 1'b0)
                    check("R7 idle line high", 32'({busy, tx}), 32'b01);
            end
            check("R7 idle after dump", 32'({busy, tx}), 32'b01);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = VEC[i][6:1];
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 tx idle", 32'(tx), 32'd1);
        check("R1 busy low", 32'(busy), 32'd0);
        check("R1 done low", 32'(done), 32'd0);
        check("R1 address zero", 32'(rd_addr), 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", 32'(busy), 32'd1);
        check("R2 address zero", 32'(rd_addr), 32'd0);
        run_dump(1'b1, 1'b1);   // busy-time poke, then restart in done cycle
        run_dump(1'b0, 1'b0);   // dump launched by the restart
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= 20000);
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule